// File: doc/BRIEF.md
# Boot Image Loader for a Serial Configuration Memory

This block runs once after reset. It reads a boot image from a serial configuration memory, one byte per request, over a byte-level read handshake. The bit-level two-wire signalling sits in a separate engine. The image opens with a signature byte. Two configuration registers follow it, then a second signature byte and a 16-bit length field.

A length of exactly six selects a compact identity record. That record holds vendor, product and device IDs, and the block captures them into registers. Any other length selects a raw descriptor stream of that many bytes. The block passes the stream out on a valid/ready byte port, and it does not fetch the next memory byte until the current one has been accepted. When the record or the stream is finished, the block raises a one-cycle enumeration-done pulse.

If the memory does not answer the first read, or the first signature is wrong, the block flags that an external master must supply the descriptors. A failure later in the image, or an oversized length, ends the load with an error flag. A 3-bit address strap tells the read engine whether the memory expects one or two address bytes.

Top module: `boot_image_loader`

## Requirements
- R1: While reset is asserted, all outputs are zero. After reset release the block reads image bytes at addresses 0, 1, 2, and so on, one per request. Each request stays high with a stable address until the memory answers with `mem_vld` or `mem_nack`.
- R2: `mem_addr_two` is high (two address bytes) when `addr_strap` is 3'b001. It is low (one address byte) for every other strap value, including 3'b000.
- R3: If the byte-0 read is nacked, or byte 0 is not 8'hC4, the block sets `use_master` and `boot_done`. It issues no further read, leaves every register at zero, and raises neither `load_err` nor `enum_done`.
- R4: When byte 0 is 8'hC4, byte 1 is loaded into `if_cfg` and byte 2 into `polarity`.
- R5: When byte 3 is not 8'hC4, the load stops after four reads. The block sets `boot_done` without `enum_done`, `load_err` or `use_master`.
- R6: Bytes 4 and 5 form the length, low byte first. A length of 6 captures bytes 6 to 11 as `vendor_id`, `product_id` and `device_id`, each low byte first, and produces no descriptor output.
- R7: Any other length N of at most 4096 streams bytes 6 to 5+N out on `desc_data` in order. Each byte is held with `desc_valid` until `desc_ready`, and no memory request is issued while `desc_valid` is high.
- R8: `enum_done` pulses for exactly one cycle, together with the rise of `boot_done`. This happens after the last descriptor byte is accepted, or after the last ID byte is read, or directly after byte 5 when N is 0.
- R9: A length above 4096 sets `load_err` and `boot_done` after six reads. No descriptor byte is output and no `enum_done` is raised.
- R10: A nack on any read after byte 0 sets `load_err` and `boot_done`. Registers loaded before the nack keep their values, and `enum_done` is not raised.
- R11: `boot_done` stays high until the next reset. While it is high there is no memory request and no descriptor output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 3 | Memory device-address strap; selects the address format |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 16 | Image byte address of the request |
| mem_addr_two | output | 1 | Memory takes two address bytes |
| mem_vld | input | 1 | Read data valid (one cycle) |
| mem_nack | input | 1 | Read failed or no device (one cycle) |
| mem_data | input | 8 | Read data byte |
| desc_data | output | 8 | Descriptor stream byte |
| desc_valid | output | 1 | Descriptor byte present |
| desc_ready | input | 1 | Downstream accepts the descriptor byte |
| if_cfg | output | 8 | Interface configuration register |
| polarity | output | 8 | Polarity register |
| vendor_id | output | 16 | Vendor ID from the compact record |
| product_id | output | 16 | Product ID from the compact record |
| device_id | output | 16 | Device ID from the compact record |
| enum_done | output | 1 | Enumeration-complete pulse |
| use_master | output | 1 | Descriptors must come from the external master |
| load_err | output | 1 | Load aborted: failed read or corrupt length |
| boot_done | output | 1 | Load sequence finished |

## Verification
The bench aims at the length boundaries: 0, 6, 4096 and 4097. A loader with an off-by-one at the end of the stream would emit one byte too many or too few, or would pulse `enum_done` a cycle early. A loader that compared the length against the wrong limit would either reject the largest legal image or stream a corrupt one.

Nacks are injected at the first byte, inside the header and in the middle of the stream. These separate the hand-over-to-master outcome from the error outcome. They also expose a design that clears the registers it has already loaded.

Random backpressure on `desc_ready` together with random memory latency checks two things. A design that fetched ahead of an unaccepted byte would reorder or drop stream data. A design that dropped the request early would return the wrong bytes.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  localparam logic [7:0] BOOT_SIG   = 8'hC4;
  localparam int         HDR_LEN    = 6;   // signature, two cfg bytes, signature, length
  localparam int         DEF_ID_LEN = 6;   // compact identity record size
  typedef enum logic [1:0] {ST_ISSUE, ST_WAIT, ST_EMIT, ST_DONE} bl_state_e;
endpackage

// File: rtl/bootld_rstsync.sv
module bootld_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bootld_fetch.sv
module bootld_fetch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic              mem_vld,
  input  logic              mem_nack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              got,
  output logic              nak
);
  logic req_q, req_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    req_d = req_q;
    if (go)                               req_d = 1'b1;
    else if (req_q && (mem_vld || mem_nack)) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= req_d;
      if (go) addr_q <= go_addr;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign nak      = req_q & mem_nack;
  assign got      = req_q & mem_vld & ~mem_nack;
endmodule

// File: rtl/bootld_idrec.sv
module bootld_idrec #(
  parameter int NBYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  sel,
  input  logic [7:0]  din,
  output logic [15:0] vid,
  output logic [15:0] pid,
  output logic [15:0] did
);
  logic [NBYTES*8-1:0] flat;

  generate
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     q <= '0;
        else if (we && sel == 3'(i))    q <= din;
      end
      assign flat[i*8 +: 8] = q;
    end
  endgenerate

  assign vid = flat[15:0];
  assign pid = flat[31:16];
  assign did = flat[47:32];
endmodule

// File: rtl/bootld_ctrl.sv
module bootld_ctrl
  import bootld_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MAX_DESC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              got,
  input  logic              nak,
  input  logic [7:0]        rdata,
  input  logic              desc_ready,
  output logic              go,
  output logic [ADDR_W-1:0] go_addr,
  output logic [7:0]        ifc,
  output logic [7:0]        pol,
  output logic              id_we,
  output logic [2:0]        id_sel,
  output logic              desc_valid,
  output logic [7:0]        desc_data,
  output logic              enum_done,
  output logic              use_master,
  output logic              load_err,
  output logic              boot_done
);
  localparam logic [ADDR_W-1:0] MAX_L   = ADDR_W'(MAX_DESC);
  localparam logic [ADDR_W-1:0] HDR_A   = ADDR_W'(HDR_LEN);
  localparam logic [ADDR_W-1:0] DEF_L   = ADDR_W'(DEF_ID_LEN);
  localparam logic [ADDR_W-1:0] ID_LAST = ADDR_W'(HDR_LEN + DEF_ID_LEN - 1);

  bl_state_e st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d, len_q, len_d, len_full;
  logic [7:0] ifc_q, ifc_d, pol_q, pol_d, dat_q, dat_d;
  logic xm_q, xm_d, err_q, err_d, fin_q, fin_d, eok_q, eok_d;

  assign len_full = ADDR_W'({rdata, len_q[7:0]});

  always_comb begin
    st_d = st_q;   idx_d = idx_q; len_d = len_q;
    ifc_d = ifc_q; pol_d = pol_q; dat_d = dat_q;
    xm_d = xm_q;   err_d = err_q; fin_d = fin_q; eok_d = 1'b0;
    go = 1'b0;     id_we = 1'b0;
    id_sel = 3'(idx_q - HDR_A);
    case (st_q)
      ST_ISSUE: begin
        go   = 1'b1;
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (nak) begin
          st_d  = ST_DONE;
          fin_d = 1'b1;
          if (idx_q == '0) xm_d  = 1'b1;
          else             err_d = 1'b1;
        end else if (got) begin
          st_d  = ST_ISSUE;
          idx_d = idx_q + 1'b1;
          if (idx_q == ADDR_W'(0)) begin
            if (rdata != BOOT_SIG) begin
              st_d = ST_DONE; fin_d = 1'b1; xm_d = 1'b1;
            end
          end else if (idx_q == ADDR_W'(1)) begin
            ifc_d = rdata;
          end else if (idx_q == ADDR_W'(2)) begin
            pol_d = rdata;
          end else if (idx_q == ADDR_W'(3)) begin
            if (rdata != BOOT_SIG) begin
              st_d = ST_DONE; fin_d = 1'b1;
            end
          end else if (idx_q == ADDR_W'(4)) begin
            len_d = ADDR_W'(rdata);
          end else if (idx_q == ADDR_W'(5)) begin
            len_d = len_full;
            if (len_full > MAX_L) begin
              st_d = ST_DONE; fin_d = 1'b1; err_d = 1'b1;
            end else if (len_full == '0) begin
              st_d = ST_DONE; fin_d = 1'b1; eok_d = 1'b1;
            end
          end else if (len_q == DEF_L) begin
            id_we = 1'b1;
            if (idx_q == ID_LAST) begin
              st_d = ST_DONE; fin_d = 1'b1; eok_d = 1'b1;
            end
          end else begin
            dat_d = rdata;
            st_d  = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (desc_ready) begin
          if (idx_q - HDR_A == len_q) begin
            st_d = ST_DONE; fin_d = 1'b1; eok_d = 1'b1;
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ISSUE; idx_q <= '0; len_q <= '0;
      ifc_q <= '0; pol_q <= '0; dat_q <= '0;
      xm_q <= 1'b0; err_q <= 1'b0; fin_q <= 1'b0; eok_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; len_q <= len_d;
      ifc_q <= ifc_d; pol_q <= pol_d; dat_q <= dat_d;
      xm_q <= xm_d; err_q <= err_d; fin_q <= fin_d; eok_q <= eok_d;
    end
  end

  assign go_addr    = idx_q;
  assign ifc        = ifc_q;
  assign pol        = pol_q;
  assign desc_valid = (st_q == ST_EMIT);
  assign desc_data  = dat_q;
  assign enum_done  = eok_q;
  assign use_master = xm_q;
  assign load_err   = err_q;
  assign boot_done  = fin_q;
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader #(
  parameter int ADDR_W      = 16,
  parameter int MAX_DESC    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr_strap,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_two,
  input  logic              mem_vld,
  input  logic              mem_nack,
  input  logic [7:0]        mem_data,
  output logic [7:0]        desc_data,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [7:0]        if_cfg,
  output logic [7:0]        polarity,
  output logic [15:0]       vendor_id,
  output logic [15:0]       product_id,
  output logic [15:0]       device_id,
  output logic              enum_done,
  output logic              use_master,
  output logic              load_err,
  output logic              boot_done
);
  localparam logic [2:0] STRAP_TWO = 3'b001;

  logic rst_sn, go, got, nak, id_we;
  logic [ADDR_W-1:0] go_addr;
  logic [2:0] id_sel;

  bootld_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  bootld_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_sn), .go(go), .go_addr(go_addr),
    .mem_vld(mem_vld), .mem_nack(mem_nack), .mem_req(mem_req),
    .mem_addr(mem_addr), .got(got), .nak(nak));

  bootld_ctrl #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .got(got), .nak(nak), .rdata(mem_data),
    .desc_ready(desc_ready), .go(go), .go_addr(go_addr), .ifc(if_cfg),
    .pol(polarity), .id_we(id_we), .id_sel(id_sel), .desc_valid(desc_valid),
    .desc_data(desc_data), .enum_done(enum_done), .use_master(use_master),
    .load_err(load_err), .boot_done(boot_done));

  bootld_idrec #(.NBYTES(6)) u_id (
    .clk(clk), .rst_n(rst_sn), .we(id_we), .sel(id_sel), .din(mem_data),
    .vid(vendor_id), .pid(product_id), .did(device_id));

  assign mem_addr_two = (addr_strap == STRAP_TWO);
endmodule

// File: rtl/bootld_chk.sv
module bootld_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_vld,
  input logic              mem_nack,
  input logic [7:0]        desc_data,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              enum_done,
  input logic              use_master,
  input logic              load_err,
  input logic              boot_done
);
  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_vld && !mem_nack |=> mem_req && $stable(mem_addr));

  // R7
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_data));

  // R7
  no_fetch_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !mem_req);

  // R8
  enum_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enum_done |=> !enum_done);

  // R8
  enum_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enum_done |-> boot_done && !load_err && !use_master);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !mem_req && !desc_valid);
endmodule

bind boot_image_loader bootld_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_vld(mem_vld), .mem_nack(mem_nack), .desc_data(desc_data),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .enum_done(enum_done),
  .use_master(use_master), .load_err(load_err), .boot_done(boot_done));

// File: tb/boot_image_loader_test.sv
module boot_image_loader_test;
  localparam int CLK_P = 10;
  localparam int LIMIT = 60000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr_strap = '0;
  logic mem_req, mem_addr_two, desc_valid, enum_done, use_master, load_err, boot_done;
  logic [15:0] mem_addr, vendor_id, product_id, device_id;
  logic mem_vld = 1'b0, mem_nack = 1'b0, desc_ready = 1'b0;
  logic [7:0] mem_data = '0;
  logic [7:0] desc_data, if_cfg, polarity;

  int n_chk = 0, n_fail = 0;
  logic [7:0] hdr [6];
  int salt;

  always #(CLK_P/2) clk = ~clk;

  boot_image_loader uut (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_addr_two(mem_addr_two), .mem_vld(mem_vld),
    .mem_nack(mem_nack), .mem_data(mem_data), .desc_data(desc_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .if_cfg(if_cfg),
    .polarity(polarity), .vendor_id(vendor_id), .product_id(product_id),
    .device_id(device_id), .enum_done(enum_done), .use_master(use_master),
    .load_err(load_err), .boot_done(boot_done));

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] img(input int i);
    if (i < 6) return hdr[i];
    return 8'((i * 37 + salt) & 255);
  endfunction

  task automatic run_case(input logic [2:0] strap, input logic [7:0] b0, b1, b2, b3,
                          input int len, input int nack_at, input int s);
    int nat, n_ok, exp_reads, reads, got_desc, bad_desc, enums, late_req, cyc, post, dly, exp_desc;
    bit addr_ok, two_ok, aborted, xm_e, err_e, enum_e, dflt, r;
    logic [7:0] e [6];
    hdr[0] = b0; hdr[1] = b1; hdr[2] = b2; hdr[3] = b3;
    hdr[4] = 8'(len); hdr[5] = 8'(len >> 8);
    salt = s;
    reads = 0; got_desc = 0; bad_desc = 0; enums = 0; late_req = 0; cyc = 0; post = -1; dly = 0;
    addr_ok = 1; two_ok = 1;
    @(negedge clk);
    rst_n = 1'b0; addr_strap = strap; mem_vld = 0; mem_nack = 0; desc_ready = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!boot_done && !mem_req && !desc_valid && !enum_done && if_cfg == 0 &&
        vendor_id == 0 && !use_master && !load_err, "R1 reset state",
        {boot_done, mem_req, desc_valid, enum_done, use_master, load_err}, 0);
    rst_n = 1'b1;
    while (post != 0) begin
      @(negedge clk);
      cyc++;
      if (cyc >= LIMIT) break;
      if (enum_done) enums++;
      if (boot_done && mem_req) late_req++;
      mem_vld = 1'b0; mem_nack = 1'b0;
      r = ($urandom % 4) != 0;
      if (desc_valid && r) begin
        if (desc_data !== img(6 + got_desc)) bad_desc++;
        got_desc++;
      end
      desc_ready = r;
      if (mem_req && !boot_done) begin
        if (dly > 0) dly--;
        else begin
          if (mem_addr !== 16'(reads)) addr_ok = 0;
          if (mem_addr_two !== (strap == 3'b001)) two_ok = 0;
          if (reads == nack_at) mem_nack = 1'b1;
          else begin mem_vld = 1'b1; mem_data = img(reads); end
          reads++;
          dly = $urandom % 3;
        end
      end
      if (boot_done && post < 0) post = 4;
      else if (post > 0) post--;
    end
    if (post != 0) chk(0, "R11 watchdog expired", cyc, LIMIT);

    // expected outcome from the image contents
    if (b0 != 8'hC4)      nat = 1;
    else if (b3 != 8'hC4) nat = 4;
    else if (len > 4096)  nat = 6;
    else if (len == 6)    nat = 12;
    else                  nat = 6 + len;
    aborted   = (nack_at >= 0) && (nack_at < nat);
    n_ok      = aborted ? nack_at : nat;
    exp_reads = aborted ? nack_at + 1 : nat;
    xm_e   = aborted ? (nack_at == 0) : (b0 != 8'hC4);
    err_e  = aborted ? (nack_at != 0) : (b0 == 8'hC4 && b3 == 8'hC4 && len > 4096);
    enum_e = !aborted && b0 == 8'hC4 && b3 == 8'hC4 && len <= 4096;
    dflt   = b0 == 8'hC4 && b3 == 8'hC4 && len == 6;
    exp_desc = (!dflt && b0 == 8'hC4 && b3 == 8'hC4 && len <= 4096 && n_ok > 6) ? n_ok - 6 : 0;
    for (int j = 0; j < 6; j++) e[j] = (dflt && 6 + j < n_ok) ? img(6 + j) : 8'h00;

    chk(addr_ok, "R1 sequential read addresses", addr_ok, 1);
    chk(reads == exp_reads, aborted ? "R10 read count" : "R1 read count", reads, exp_reads);
    chk(two_ok, "R2 address byte count follows strap", two_ok, 1);
    chk(use_master == xm_e, "R3 use_master", use_master, xm_e);
    chk(load_err == err_e, aborted ? "R10 load_err" : "R9 load_err", load_err, err_e);
    chk(enums == (enum_e ? 1 : 0), "R8 enum_done pulse count", enums, enum_e ? 1 : 0);
    chk(boot_done == 1'b1, "R11 boot_done", boot_done, 1);
    chk(late_req == 0, "R11 no request after done", late_req, 0);
    chk(if_cfg == ((n_ok > 1) ? b1 : 8'h00), "R4 if_cfg", if_cfg, (n_ok > 1) ? b1 : 8'h00);
    chk(polarity == ((n_ok > 2) ? b2 : 8'h00), "R4 polarity", polarity, (n_ok > 2) ? b2 : 8'h00);
    chk(vendor_id == {e[1], e[0]} && product_id == {e[3], e[2]} && device_id == {e[5], e[4]},
        "R6 identity record", {vendor_id, product_id, device_id}, {e[1], e[0], e[3], e[2], e[5], e[4]});
    chk(got_desc == exp_desc, "R7 descriptor byte count", got_desc, exp_desc);
    chk(bad_desc == 0, "R7 descriptor byte order", bad_desc, 0);
    if (b0 == 8'hC4 && b3 != 8'hC4 && !aborted)
      chk(reads == 4 && !use_master && !load_err, "R5 stop after second signature", reads, 4);
    if (b0 != 8'hC4 && !aborted)
      chk(reads == 1, "R3 no read after bad signature", reads, 1);
  endtask

  initial begin
    int len, nk;
    logic [2:0] st;
    void'($urandom(32'd7741));
    run_case(3'b000, 8'hC4, 8'h11, 8'h22, 8'hC4, 10, 0, 3);     // R3 absent memory
    run_case(3'b001, 8'hC5, 8'h11, 8'h22, 8'hC4, 10, -1, 3);    // R3 bad first signature
    run_case(3'b001, 8'hC4, 8'hA5, 8'h5A, 8'h00, 10, -1, 5);    // R4 R5 config only
    run_case(3'b000, 8'hC4, 8'h3C, 8'hC3, 8'hC4, 6, -1, 9);     // R6 compact record
    run_case(3'b101, 8'hC4, 8'h01, 8'h02, 8'hC4, 0, -1, 1);     // R8 zero length
    run_case(3'b001, 8'hC4, 8'h0F, 8'hF0, 8'hC4, 4097, -1, 2);  // R9 oversize
    run_case(3'b001, 8'hC4, 8'h77, 8'h88, 8'hC4, 4096, -1, 4);  // R7 largest image
    run_case(3'b000, 8'hC4, 8'h99, 8'h66, 8'hC4, 20, 2, 6);     // R10 nack in header
    run_case(3'b001, 8'hC4, 8'h12, 8'h34, 8'hC4, 30, 14, 8);    // R10 nack in stream
    run_case(3'b000, 8'hC4, 8'h56, 8'h78, 8'hC4, 6, 9, 10);     // R10 nack in record
    for (int k = 0; k < 12; k++) begin
      len = 1 + ($urandom % 40);
      if (len == 6) len = 7;
      st = 3'($urandom % 4);
      nk = (($urandom % 4) == 0) ? int'($urandom % (6 + len)) : -1;
      run_case(st, 8'hC4, 8'($urandom), 8'($urandom), 8'hC4, len, nk, int'($urandom % 256));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule